// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of a read or write burst in a synchronous DRAM with a 9-bit column address. A start strobe loads a start column, a length code and an ordering choice. From the following cycle the block presents one column address per clock, together with a valid flag and a flag that marks the final beat.

Fixed bursts of 1, 2, 4 or 8 beats may use either ordering. The sequential ordering counts within an aligned group of columns and wraps inside that group. The interleaved ordering XORs the beat number into the low column bits. A full-page burst counts through all columns, wraps from the top column back to zero, and runs until it is stopped or replaced. A new start on any cycle replaces the running burst. A stop input ends the burst on any cycle.

The control is a three-state machine:
- IDLE: no burst.
- FIXED: a burst of fixed length.
- PAGE: an endless full-page burst.

The transitions are:
- LAUNCH: IDLE to FIXED or PAGE on start.
- RESTART: FIXED or PAGE back to FIXED or PAGE on start.
- FINISH: FIXED to IDLE on the final beat.
- ABORT: FIXED or PAGE to IDLE on stop.
- HOLD: stay in the current state when none of the above applies.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, valid_o is 0, last_o is 0 and col_o is 0.
- R2: When start_i is high at a rising edge, then from the next cycle valid_o is 1 and col_o equals the sampled start_col_i (beat 0). Each further beat follows one cycle later.
- R3: With len_code_i[2] = 0 and interleave_i = 0, the burst length is 2^len_code_i[1:0] (codes 0, 1, 2, 3 give 1, 2, 4, 8 beats). Beat n keeps the column bits above the low log2(length) bits. Its low bits are (start + n) mod length.
- R4: With len_code_i[2] = 0 and interleave_i = 1, the burst length is the same as in R3, and beat n is the start column XOR n.
- R5: last_o is 1 exactly on the final beat of a fixed burst. If no start arrives, valid_o is 0 in the following cycle.
- R6: With len_code_i[2] = 1 and interleave_i = 0 (full page), beat n is (start + n) mod 512. The burst wraps from 511 to 0, continues without end, and never raises last_o.
- R7: With len_code_i[2] = 1 and interleave_i = 1, the burst behaves as an interleaved burst of 8 beats.
- R8: When stop_i is high and start_i is low at a rising edge during a burst, valid_o and last_o are 0 from the next cycle.
- R9: A start during a burst restarts from the new start column with the new length and ordering. When start_i and stop_i are high together, the start wins.
- R10: With no burst running, stop_i has no effect: valid_o stays 0 until a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new burst |
| start_col_i | input | 9 | First column of the burst |
| len_code_i | input | 3 | Bit 2 selects full page; bits 1:0 give log2 of the fixed length |
| interleave_i | input | 1 | 1 selects interleaved order, 0 selects sequential order |
| stop_i | input | 1 | End the running burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The first beat is due one cycle after the edge that samples the start, and each later beat follows one cycle after the previous one. The drop of valid_o is due one cycle after the final beat or after the edge that samples a stop. The bench changes inputs only on falling edges and reads outputs on the next falling edge, so each read sees exactly one new register update. Sweeps over every fixed length, both orderings and start columns near the edges of the column space compare each beat with a value worked out arithmetically. Full-page wrap, interruption and the start-over-stop priority are checked at the exact cycle each result is due.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [1:0] {
        BCG_IDLE  = 2'd0,
        BCG_FIXED = 2'd1,
        BCG_PAGE  = 2'd2
    } bcg_state_t;

endpackage

// File: rtl/bcg_order.sv
module bcg_order #(
    parameter int COL_W = 9,
    parameter int LOG_W = 2
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [LOG_W-1:0] log_i,
    input  logic             ilv_i,
    input  logic             page_i,
    output logic [COL_W-1:0] col_o,
    output logic             at_end_o
);

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] xor_col;
    logic [COL_W-1:0] lin_col;

    always_comb begin
        mask    = (COL_W'(1) << log_i) - COL_W'(1);
        seq_col = (base_i & ~mask) | ((base_i + beat_i) & mask);
        xor_col = base_i ^ (beat_i & mask);
        lin_col = base_i + beat_i;
        if (page_i) begin
            col_o = lin_col;
        end else if (ilv_i) begin
            col_o = xor_col;
        end else begin
            col_o = seq_col;
        end
        at_end_o = ((beat_i & mask) == mask);
    end

endmodule

// File: rtl/bcg_fsm.sv
module bcg_fsm
    import bcg_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 3,
    parameter int LOG_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [LOG_W:0]   len_code_i,
    input  logic             interleave_i,
    input  logic             stop_i,
    input  logic             at_end_i,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_o,
    output logic [LOG_W-1:0] log_o,
    output logic             ilv_o,
    output logic             page_o,
    output logic             valid_o,
    output logic             last_o
);

    bcg_state_t       state_q, state_d, launch_state;
    logic             want_page;
    logic [LOG_W-1:0] launch_log;
    logic [COL_W-1:0] base_q, beat_q;
    logic [LOG_W-1:0] log_q;
    logic             ilv_q;

    // Length decode; interleaved full page falls back to the longest fixed burst
    always_comb begin
        want_page    = len_code_i[LOG_W] & ~interleave_i;
        launch_log   = len_code_i[LOG_W] ? LOG_W'(MAX_LOG) : len_code_i[LOG_W-1:0];
        launch_state = want_page ? BCG_PAGE : BCG_FIXED;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BCG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: LAUNCH, RESTART, FINISH, ABORT, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BCG_IDLE: begin
                if (start_i) state_d = launch_state;
            end
            BCG_FIXED: begin
                if (start_i)                 state_d = launch_state;
                else if (stop_i || at_end_i) state_d = BCG_IDLE;
            end
            BCG_PAGE: begin
                if (start_i)     state_d = launch_state;
                else if (stop_i) state_d = BCG_IDLE;
            end
            default: state_d = BCG_IDLE;
        endcase
    end

    // Burst context and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            log_q  <= '0;
            ilv_q  <= 1'b0;
        end else if (start_i) begin
            base_q <= start_col_i;
            beat_q <= '0;
            log_q  <= launch_log;
            ilv_q  <= interleave_i;
        end else if (state_q != BCG_IDLE) begin
            beat_q <= beat_q + COL_W'(1);
        end
    end

    // Outputs
    always_comb begin
        base_o  = base_q;
        beat_o  = beat_q;
        log_o   = log_q;
        ilv_o   = ilv_q;
        page_o  = (state_q == BCG_PAGE);
        valid_o = (state_q != BCG_IDLE);
        last_o  = (state_q == BCG_FIXED) && at_end_i;
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 3,
    parameter int LOG_W   = $clog2(MAX_LOG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [LOG_W:0]   len_code_i,
    input  logic             interleave_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);

    logic [COL_W-1:0] base, beat;
    logic [LOG_W-1:0] log_len;
    logic             ilv, page, at_end;

    bcg_fsm #(
        .COL_W  (COL_W),
        .MAX_LOG(MAX_LOG),
        .LOG_W  (LOG_W)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len_code_i  (len_code_i),
        .interleave_i(interleave_i),
        .stop_i      (stop_i),
        .at_end_i    (at_end),
        .base_o      (base),
        .beat_o      (beat),
        .log_o       (log_len),
        .ilv_o       (ilv),
        .page_o      (page),
        .valid_o     (valid_o),
        .last_o      (last_o)
    );

    bcg_order #(
        .COL_W(COL_W),
        .LOG_W(LOG_W)
    ) i_order (
        .base_i  (base),
        .beat_i  (beat),
        .log_i   (log_len),
        .ilv_i   (ilv),
        .page_i  (page),
        .col_o   (col_o),
        .at_end_o(at_end)
    );

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int COL_W = 9,
    parameter int LOG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [LOG_W:0]   len_code_i,
    input logic             interleave_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);

    logic pg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q <= 1'b0;
        end else if (start_i) begin
            pg_q <= len_code_i[LOG_W] & ~interleave_i;
        end
    end

    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (!valid_o && !last_o));

    a_r5_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    a_r5_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_q && valid_o && !start_i && !stop_i) |=>
            (valid_o && !last_o && col_o == COL_W'($past(col_o) + 1)));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> !valid_o);

endmodule

bind burst_col_gen bcg_checker #(
    .COL_W(COL_W),
    .LOG_W(LOG_W)
) i_bcg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_code_i  (len_code_i),
    .interleave_i(interleave_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
);

// File: tb/test_burst_col_gen.sv
`timescale 1ns/1ps
module test_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       interleave_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       last_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    burst_col_gen i_burst_col_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len_code_i  (len_code_i),
        .interleave_i(interleave_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o)
    );

    task automatic chk(string what, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    function automatic int exp_col(int s, int lg, bit il, bit pg, int n);
        int len;
        len = 1 << lg;
        if (pg) return (s + n) % 512;
        if (il) return s ^ n;
        return s - (s % len) + (((s % len) + n) % len);
    endfunction

    // Inputs set on the current falling edge, cleared on the next one,
    // where beat 0 is already visible.
    task automatic launch(int s, int code, bit il, bit also_stop);
        start_i      = 1'b1;
        stop_i       = also_stop;
        start_col_i  = 9'(s);
        len_code_i   = 3'(code);
        interleave_i = il;
        @(negedge clk);
        start_i = 1'b0;
        stop_i  = 1'b0;
    endtask

    task automatic beats(string req, int s, int lg, bit il, bit pg, int nb);
        for (int n = 0; n < nb; n++) begin
            if (n > 0) @(negedge clk);
            chk({req, " col"}, int'(col_o), exp_col(s, lg, il, pg, n));
            chk({req, " valid"}, int'(valid_o), 1);
            chk({req, " last"}, int'(last_o), (!pg && n == (1 << lg) - 1) ? 1 : 0);
        end
    endtask

    task automatic expect_idle(string req);
        @(negedge clk);
        chk({req, " valid drop"}, int'(valid_o), 0);
        chk({req, " last drop"}, int'(last_o), 0);
    endtask

    initial begin
        int starts[6] = '{0, 5, 13, 250, 506, 511};
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 last", int'(last_o), 0);
        chk("R1 col", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", int'(valid_o), 0);

        // R2 R3 R4 R5 sweep of fixed bursts
        for (int code = 0; code < 4; code++) begin
            for (int il = 0; il < 2; il++) begin
                for (int k = 0; k < 6; k++) begin
                    launch(starts[k], code, il[0], 1'b0);
                    chk("R2 first beat", int'(col_o), starts[k]);
                    beats(il ? "R4" : "R3", starts[k], code, il[0], 1'b0, 1 << code);
                    expect_idle("R5");
                end
            end
        end

        // R6 full page with wrap, then stop (R8)
        launch(508, 4, 1'b0, 1'b0);
        beats("R6", 508, 3, 1'b0, 1'b1, 12);
        @(negedge clk);
        chk("R6 beat 12", int'(col_o), 8);
        chk("R6 no last", int'(last_o), 0);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 valid after stop", int'(valid_o), 0);
        chk("R8 last after stop", int'(last_o), 0);

        // R6 other full-page code
        launch(100, 7, 1'b0, 1'b0);
        beats("R6 code7", 100, 3, 1'b0, 1'b1, 3);
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 valid after stop code7", int'(valid_o), 0);

        // R7 interleaved full page acts as interleaved length 8
        launch(509, 4, 1'b1, 1'b0);
        beats("R7", 509, 3, 1'b1, 1'b0, 8);
        expect_idle("R7");

        // R8 stop in a fixed burst
        launch(40, 3, 1'b0, 1'b0);
        beats("R8 pre", 40, 3, 1'b0, 1'b0, 2);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 fixed stop valid", int'(valid_o), 0);

        // R9 restart mid-burst with a new mode
        launch(3, 3, 1'b0, 1'b0);
        beats("R9 pre", 3, 3, 1'b0, 1'b0, 3);
        launch(100, 1, 1'b0, 1'b0);
        beats("R9 restart", 100, 1, 1'b0, 1'b0, 2);
        expect_idle("R9");

        // R9 restart a page burst into interleaved 4, start with stop
        launch(510, 4, 1'b0, 1'b0);
        beats("R9 page pre", 510, 3, 1'b0, 1'b1, 4);
        launch(41, 2, 1'b1, 1'b1);
        beats("R9 start wins", 41, 2, 1'b1, 1'b0, 4);
        expect_idle("R9 end");

        // R10 stop while idle
        stop_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 idle valid", int'(valid_o), 0);
            chk("R10 idle last", int'(last_o), 0);
        end
        stop_i = 1'b0;
        launch(7, 1, 1'b0, 1'b0);
        beats("R10 after idle stop", 7, 1, 1'b0, 1'b0, 2);
        expect_idle("R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule